// File: doc/BRIEF.md
# Keyed Configuration Register Controller

This block is the configuration front end of a multi-function I/O device. The host reaches it through two byte-wide ports: an index port and a data port. At power-on the register file is locked. A fixed two-byte key written to the index port opens it, and a single exit byte locks it again. While it is open, the host writes a register number to the index port and then moves the value through the data port.

A global selector register chooses one logical device. All registers numbered 0x30 and above are banked per device. They hold an enable bit, a 16-bit I/O base, two interrupt numbers, a DMA channel and a small set of device-specific mode bytes. The decoded settings of every device are presented on flat output buses, ready for the peripheral functions to use. A soft-reset register clears all banked settings without locking the file.

Top module: `cfg_keyed_regs`

## Requirements
- R1: After rst_ni is asserted, the file is locked (cfg_open_o = 0). All enable, base, interrupt, DMA and mode outputs are zero, and reads of either port return 0xFF.
- R2: An index-port write of 0x51 followed directly by an index-port write of 0x23 opens the file. cfg_open_o is 1 in the cycle after the second write.
- R3: If any index-port byte other than 0x23 follows 0x51, the key detector returns to idle. This includes a second 0x51. A later lone 0x23 does not open the file.
- R4: While the file is locked, data-port writes change no register, and data-port reads return 0xFF.
- R5: While the file is open, an index-port write of 0xBB locks it in the next cycle. Data-port writes after that are ignored.
- R6: While the file is open, an index-port read returns the last register number written. While locked, it returns 0xFF.
- R7: Global register 0x07 holds the logical device number and reads back its value. Writes and reads of registers 0x30 and above go only to the bank of the selected device.
- R8: Within a bank, register 0x30 bit 0 is the device enable and reads back as {7'b0, enable}. Registers 0x60 and 0x61 are the high and low base bytes. Register 0x70 is the first interrupt, 0x72 the second interrupt and 0x74 the DMA channel. All of these read back as written.
- R9: Bank registers 0xF0 to 0xF0+NUM_MODE-1 are per-device mode bytes. They appear on dev_mode_o at byte (device*NUM_MODE + mode number) and read back as written.
- R10: A data write with bit 0 set to global register 0x02 clears every banked register and the device selector in the next cycle, and leaves the file open. A write with bit 0 clear has no effect.
- R11: When the device selector is NUM_DEV or above, bank writes change nothing and bank reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_wr_i | input | 1 | Host write strobe, one cycle per byte |
| io_sel_i | input | 1 | Port select: 0 index port, 1 data port |
| io_wdata_i | input | 8 | Host write byte |
| io_rdata_o | output | 8 | Read value of the port chosen by io_sel_i (combinational) |
| cfg_open_o | output | 1 | Configuration mode active |
| dev_en_o | output | NUM_DEV | Per-device enable |
| dev_base_o | output | 16*NUM_DEV | Per-device I/O base, device d at bits [16d+15:16d] |
| dev_irq_a_o | output | 8*NUM_DEV | Per-device first interrupt number |
| dev_irq_b_o | output | 8*NUM_DEV | Per-device second interrupt number |
| dev_dma_o | output | 8*NUM_DEV | Per-device DMA channel |
| dev_mode_o | output | 8*NUM_DEV*NUM_MODE | Per-device mode bytes |

## Verification
The assertions assume the host issues at most one strobe per cycle and holds io_sel_i and io_wdata_i valid while io_wr_i is high. They also assume reads are sampled combinationally from the port selected by io_sel_i. The bench drives every access through one write task and one read task. Both change inputs only on the falling edge and hold the strobe for exactly one cycle, so no overlapping or partial accesses reach the block. Key sequences are issued back to back on the index port with no interleaved data accesses, except where a test deliberately breaks the key.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h51;
  localparam logic [7:0] KEY_SECOND = 8'h23;
  localparam logic [7:0] KEY_EXIT   = 8'hBB;

  localparam logic [7:0] IDX_SRST   = 8'h02;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_BANK   = 8'h30;
  localparam logic [7:0] IDX_EN     = 8'h30;
  localparam logic [7:0] IDX_BASE_H = 8'h60;
  localparam logic [7:0] IDX_BASE_L = 8'h61;
  localparam logic [7:0] IDX_IRQ_A  = 8'h70;
  localparam logic [7:0] IDX_IRQ_B  = 8'h72;
  localparam logic [7:0] IDX_DMA    = 8'h74;
  localparam logic [7:0] IDX_MODE   = 8'hF0;

  localparam logic [7:0] LOCKED_RD  = 8'hFF;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] byte_i,
  output logic       open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        KEY_IDLE: if (byte_i == KEY_FIRST) state_d = KEY_HALF;
        KEY_HALF: state_d = (byte_i == KEY_SECOND) ? KEY_OPEN : KEY_IDLE;
        KEY_OPEN: if (byte_i == KEY_EXIT) state_d = KEY_IDLE;
        default:  state_d = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == KEY_OPEN);
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_pkg::*;
#(
  parameter int NUM_MODE = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic [7:0]            idx_i,
  input  logic [7:0]            wdata_i,
  output logic                  en_o,
  output logic [15:0]           base_o,
  output logic [7:0]            irq_a_o,
  output logic [7:0]            irq_b_o,
  output logic [7:0]            dma_o,
  output logic [NUM_MODE*8-1:0] mode_o,
  output logic [7:0]            rdata_o
);
  logic       en_q;
  logic [7:0] base_h_q, base_l_q, irq_a_q, irq_b_q, dma_q;
  logic [7:0] mode_q [NUM_MODE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      base_h_q <= '0;
      base_l_q <= '0;
      irq_a_q  <= '0;
      irq_b_q  <= '0;
      dma_q    <= '0;
    end else if (clr_i) begin
      en_q     <= 1'b0;
      base_h_q <= '0;
      base_l_q <= '0;
      irq_a_q  <= '0;
      irq_b_q  <= '0;
      dma_q    <= '0;
    end else if (wr_i) begin
      unique case (idx_i)
        IDX_EN:     en_q     <= wdata_i[0];
        IDX_BASE_H: base_h_q <= wdata_i;
        IDX_BASE_L: base_l_q <= wdata_i;
        IDX_IRQ_A:  irq_a_q  <= wdata_i;
        IDX_IRQ_B:  irq_b_q  <= wdata_i;
        IDX_DMA:    dma_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar m = 0; m < NUM_MODE; m++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mode_q[m] <= '0;
      else if (clr_i)                                mode_q[m] <= '0;
      else if (wr_i && idx_i == 8'(IDX_MODE + m))    mode_q[m] <= wdata_i;
    end
    assign mode_o[m*8 +: 8] = mode_q[m];
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IDX_EN:     rdata_o = {7'b0, en_q};
      IDX_BASE_H: rdata_o = base_h_q;
      IDX_BASE_L: rdata_o = base_l_q;
      IDX_IRQ_A:  rdata_o = irq_a_q;
      IDX_IRQ_B:  rdata_o = irq_b_q;
      IDX_DMA:    rdata_o = dma_q;
      default: begin
        for (int m = 0; m < NUM_MODE; m++) begin
          if (idx_i == 8'(IDX_MODE + m)) rdata_o = mode_q[m];
        end
      end
    endcase
  end

  assign en_o    = en_q;
  assign base_o  = {base_h_q, base_l_q};
  assign irq_a_o = irq_a_q;
  assign irq_b_o = irq_b_q;
  assign dma_o   = dma_q;
endmodule

// File: rtl/cfg_keyed_regs.sv
module cfg_keyed_regs
  import cfg_pkg::*;
#(
  parameter int NUM_DEV  = 9,
  parameter int NUM_MODE = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          io_wr_i,
  input  logic                          io_sel_i,
  input  logic [7:0]                    io_wdata_i,
  output logic [7:0]                    io_rdata_o,
  output logic                          cfg_open_o,
  output logic [NUM_DEV-1:0]            dev_en_o,
  output logic [NUM_DEV*16-1:0]         dev_base_o,
  output logic [NUM_DEV*8-1:0]          dev_irq_a_o,
  output logic [NUM_DEV*8-1:0]          dev_irq_b_o,
  output logic [NUM_DEV*8-1:0]          dev_dma_o,
  output logic [NUM_DEV*NUM_MODE*8-1:0] dev_mode_o
);
  logic       open;
  logic       idx_wr, dat_wr;
  logic [7:0] index_q;
  logic [7:0] ldn_q;
  logic       soft_clr;
  logic       bank_wr;
  logic [NUM_DEV-1:0] bank_sel;
  logic [7:0] bank_rdata [NUM_DEV];
  logic [7:0] dat_rdata;

  assign idx_wr = io_wr_i && !io_sel_i;
  assign dat_wr = io_wr_i &&  io_sel_i && open;

  cfg_key_fsm i_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_wr_i(idx_wr),
    .byte_i  (io_wdata_i),
    .open_o  (open)
  );

  // index is only captured once open; the exit byte is not kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       index_q <= '0;
    else if (open && idx_wr && io_wdata_i != KEY_EXIT) index_q <= io_wdata_i;
  end

  assign soft_clr = dat_wr && index_q == IDX_SRST && io_wdata_i[0];
  assign bank_wr  = dat_wr && index_q >= IDX_BANK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ldn_q <= '0;
    else if (soft_clr)                          ldn_q <= '0;
    else if (dat_wr && index_q == IDX_LDN)      ldn_q <= io_wdata_i;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign bank_sel[d] = (ldn_q == 8'(d));
    cfg_dev_bank #(.NUM_MODE(NUM_MODE)) i_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (soft_clr),
      .wr_i   (bank_wr && bank_sel[d]),
      .idx_i  (index_q),
      .wdata_i(io_wdata_i),
      .en_o   (dev_en_o[d]),
      .base_o (dev_base_o[d*16 +: 16]),
      .irq_a_o(dev_irq_a_o[d*8 +: 8]),
      .irq_b_o(dev_irq_b_o[d*8 +: 8]),
      .dma_o  (dev_dma_o[d*8 +: 8]),
      .mode_o (dev_mode_o[d*NUM_MODE*8 +: NUM_MODE*8]),
      .rdata_o(bank_rdata[d])
    );
  end

  always_comb begin
    dat_rdata = '0;
    if (index_q < IDX_BANK) begin
      if (index_q == IDX_LDN) dat_rdata = ldn_q;
    end else begin
      for (int d = 0; d < NUM_DEV; d++) begin
        if (bank_sel[d]) dat_rdata = bank_rdata[d];
      end
    end
  end

  assign io_rdata_o = !open    ? LOCKED_RD :
                      io_sel_i ? dat_rdata : index_q;
  assign cfg_open_o = open;
endmodule

// File: rtl/cfg_keyed_regs_chk.sv
module cfg_keyed_regs_chk #(
  parameter int NUM_DEV = 9
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  io_wr_i,
  input logic                  io_sel_i,
  input logic [7:0]            io_wdata_i,
  input logic [7:0]            io_rdata_o,
  input logic                  cfg_open_o,
  input logic [NUM_DEV-1:0]    dev_en_o,
  input logic [NUM_DEV*16-1:0] dev_base_o,
  input logic [7:0]            idx_i
);
  // R2: opening is only ever caused by the second key byte
  a_r2_open_by_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_open_o) |-> $past(io_wr_i && !io_sel_i && io_wdata_i == 8'h23));

  // R4: locked data writes leave settings untouched
  a_r4_locked_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open_o && io_wr_i && io_sel_i) |=> ($stable(dev_en_o) && $stable(dev_base_o)));

  // R4: locked reads float high
  a_r4_locked_read_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open_o |-> io_rdata_o == 8'hFF);

  // R5: exit byte locks
  a_r5_exit_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open_o && io_wr_i && !io_sel_i && io_wdata_i == 8'hBB) |=> !cfg_open_o);

  // R10: soft reset clears banks and keeps the file open
  a_r10_soft_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open_o && io_wr_i && io_sel_i && idx_i == 8'h02 && io_wdata_i[0])
    |=> (dev_en_o == '0 && dev_base_o == '0 && cfg_open_o));
endmodule

bind cfg_keyed_regs cfg_keyed_regs_chk #(.NUM_DEV(NUM_DEV)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .io_wr_i   (io_wr_i),
  .io_sel_i  (io_sel_i),
  .io_wdata_i(io_wdata_i),
  .io_rdata_o(io_rdata_o),
  .cfg_open_o(cfg_open_o),
  .dev_en_o  (dev_en_o),
  .dev_base_o(dev_base_o),
  .idx_i     (index_q)
);

// File: tb/test_cfg_keyed_regs.sv
module test_cfg_keyed_regs;
  localparam int ND = 9;
  localparam int NM = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic io_wr_i = 1'b0, io_sel_i = 1'b0;
  logic [7:0] io_wdata_i = '0;
  logic [7:0] io_rdata_o;
  logic cfg_open_o;
  logic [ND-1:0] dev_en_o;
  logic [ND*16-1:0] dev_base_o;
  logic [ND*8-1:0] dev_irq_a_o, dev_irq_b_o, dev_dma_o;
  logic [ND*NM*8-1:0] dev_mode_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cfg_keyed_regs #(.NUM_DEV(ND), .NUM_MODE(NM)) i_cfg_keyed_regs (
    .clk_i(clk), .rst_ni(rst_ni), .io_wr_i(io_wr_i), .io_sel_i(io_sel_i),
    .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o), .cfg_open_o(cfg_open_o),
    .dev_en_o(dev_en_o), .dev_base_o(dev_base_o), .dev_irq_a_o(dev_irq_a_o),
    .dev_irq_b_o(dev_irq_b_o), .dev_dma_o(dev_dma_o), .dev_mode_o(dev_mode_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] b);
    @(negedge clk);
    io_sel_i = sel; io_wdata_i = b; io_wr_i = 1'b1;
    @(negedge clk);
    io_wr_i = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] b);
    @(negedge clk);
    io_sel_i = sel;
    #1 b = io_rdata_o;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
    wr(1'b0, idx); wr(1'b1, v);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
    wr(1'b0, idx); rd(1'b1, v);
  endtask

  task automatic unlock();
    wr(1'b0, 8'h51); wr(1'b0, 8'h23);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 open", cfg_open_o, 0);
    chk("R1 en", dev_en_o, 0);
    chk("R1 base", dev_base_o[63:0], 0);
    chk("R1 mode", dev_mode_o[31:0], 0);
    rd(1'b1, v); chk("R1 data rd", v, 8'hFF);
    rd(1'b0, v); chk("R6 index rd locked", v, 8'hFF);
  endtask

  task automatic t_bad_key();
    wr(1'b0, 8'h51); wr(1'b0, 8'h00); wr(1'b0, 8'h23);
    chk("R3 broken key", cfg_open_o, 0);
    wr(1'b0, 8'h51); wr(1'b0, 8'h51); wr(1'b0, 8'h23);
    chk("R3 double first byte", cfg_open_o, 0);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    wr(1'b1, 8'h01); wr(1'b1, 8'hFF);
    chk("R4 en unchanged", dev_en_o, 0);
    rd(1'b1, v); chk("R4 read ff", v, 8'hFF);
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    unlock();
    chk("R2 open", cfg_open_o, 1);
    wr(1'b0, 8'h61);
    rd(1'b0, v); chk("R6 index readback", v, 8'h61);
    reg_rd(8'h30, v); chk("R4 locked writes lost", v, 8'h00);
  endtask

  task automatic t_fields();
    logic [7:0] v;
    reg_wr(8'h07, 8'd3);
    reg_wr(8'h30, 8'hFF); reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
    reg_wr(8'h70, 8'h07); reg_wr(8'h72, 8'h0C); reg_wr(8'h74, 8'h03);
    chk("R8 en", dev_en_o, 9'b000001000);
    chk("R8 base", dev_base_o[3*16 +: 16], 16'h1234);
    chk("R8 irq a", dev_irq_a_o[3*8 +: 8], 8'h07);
    chk("R8 irq b", dev_irq_b_o[3*8 +: 8], 8'h0C);
    chk("R8 dma", dev_dma_o[3*8 +: 8], 8'h03);
    reg_rd(8'h30, v); chk("R8 en readback", v, 8'h01);
    reg_rd(8'h61, v); chk("R8 base lo readback", v, 8'h34);
  endtask

  task automatic t_banking();
    logic [7:0] v;
    reg_wr(8'h07, 8'd4);
    reg_rd(8'h07, v); chk("R7 ldn readback", v, 8'd4);
    reg_wr(8'h60, 8'hAB);
    chk("R7 other bank kept", dev_base_o[3*16 +: 16], 16'h1234);
    chk("R7 target bank", dev_base_o[4*16 +: 16], 16'hAB00);
    reg_rd(8'h60, v); chk("R7 banked read", v, 8'hAB);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    reg_wr(8'h07, 8'd8);
    reg_wr(8'hF0, 8'h5A); reg_wr(8'hF3, 8'hC3);
    chk("R9 mode0", dev_mode_o[(8*NM+0)*8 +: 8], 8'h5A);
    chk("R9 mode3", dev_mode_o[(8*NM+3)*8 +: 8], 8'hC3);
    reg_rd(8'hF3, v); chk("R9 mode readback", v, 8'hC3);
  endtask

  task automatic t_bad_ldn();
    logic [7:0] v;
    reg_wr(8'h07, 8'd9);
    reg_wr(8'h30, 8'h01);
    chk("R11 no enable", dev_en_o, 9'b000001000);
    reg_rd(8'h30, v); chk("R11 read zero", v, 8'h00);
  endtask

  task automatic t_soft_reset();
    logic [7:0] v;
    reg_wr(8'h02, 8'h00);
    chk("R10 no-op write", dev_en_o, 9'b000001000);
    reg_wr(8'h02, 8'h01);
    chk("R10 en cleared", dev_en_o, 0);
    chk("R10 base cleared", dev_base_o[5*16-1:0], 0);
    chk("R10 mode cleared", dev_mode_o[(8*NM)*8 +: 32], 0);
    chk("R10 still open", cfg_open_o, 1);
    reg_rd(8'h07, v); chk("R10 ldn cleared", v, 8'h00);
  endtask

  task automatic t_exit();
    logic [7:0] v;
    reg_wr(8'h07, 8'd0);
    wr(1'b0, 8'h30);
    wr(1'b0, 8'hBB);
    chk("R5 locked", cfg_open_o, 0);
    wr(1'b1, 8'h01);
    chk("R5 write ignored", dev_en_o, 0);
    rd(1'b0, v); chk("R5 index rd ff", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_key();
    t_locked();
    t_unlock();
    t_fields();
    t_banking();
    t_mode();
    t_bad_ldn();
    t_soft_reset();
    t_exit();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule